// File: doc/BRIEF.md
# Split-Line SRAM Permission Checker

This block sits beside a unified instruction/data SRAM and decides, for every access, whether it may proceed. The SRAM is divided into three equal segments. Three split lines, each set by software, cut the SRAM address range into four areas. Each area carries its own read, write and execute permission bits. Every access arrives with an address and a kind (fetch, load or store). One cycle later the block reports a grant or a deny for that access.

Each split line is written as a 512-byte-granular offset within a segment, together with a 2-bit category code for each of the three segments. The checker turns this into an effective boundary address. The area of an access is the number of configured boundaries at or below its address. A sticky lock bit freezes the whole configuration until reset. A build parameter selects a data-side variant that has no execute bits, so fetches are always refused.

Configuration writes use a narrow write-only port. The lock state is the only configuration value the block drives out.

Top module: `spl_perm_check`

## Requirements
- R1: After reset the lock is clear, no result is reported, every split line is unconfigured and every permission bit is 0, so any access is denied.
- R2: A write with select 1, 2 or 3 loads split line 0, 1 or 2 respectively. Data bits [1:0], [3:2] and [5:4] are the category codes for segments 0, 1 and 2. Bits [12:6] hold the in-segment offset shifted right by 9.
- R3: A split line's effective address is the SRAM base, plus the segment index times the segment size (64 KiB), plus the offset. The segment used is the lowest-numbered one whose category is 1 or 2. A line in which no segment has category 1 or 2 is unconfigured and bounds no area.
- R4: The area of an access is the count of configured split lines whose effective address is less than or equal to the access address. An access exactly on a line belongs to the upper area.
- R5: A write with select 4 loads the permissions. Area n uses data bits [3n+2:3n], where bit 3n is read, bit 3n+1 is write and bit 3n+2 is execute.
- R6: Access kind 0 (fetch) needs the execute bit, kind 1 (load) needs the read bit and kind 2 (store) needs the write bit. Kind 3 is always denied.
- R7: An access presented in one cycle produces, on the next cycle, res_valid high and exactly one of res_grant and res_deny high. In a cycle with no access presented, all three outputs are low on the next cycle.
- R8: A write with select 0 and data bit 0 set sets the lock, and cfg_locked then reads 1. Writing 0 never clears it; only reset does.
- R9: While the lock is set, writes to the split lines and to the permissions have no effect.
- R10: With no split line configured, every address falls in area 0.
- R11: With the execute option disabled, no execute bit is stored, so every fetch is denied, while reads and writes follow their bits as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 lock, 1-3 split lines, 4 permissions |
| cfg_wdata | input | 13 | Configuration write data |
| cfg_locked | output | 1 | Lock state |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| res_valid | output | 1 | Result of the previous cycle's access |
| res_grant | output | 1 | Access permitted |
| res_deny | output | 1 | Access denied (one-cycle pulse) |

## Verification
Accesses are placed one word below, and exactly on, each effective split address. This separates a less-or-equal comparison from a strict one and exposes an off-by-one in the segment offset. Each area is probed with all three access kinds and the reserved kind, using permission patterns that differ by area, so a wrong area index or a wrong permission bit shows as a flipped grant. Split lines are rewritten with category 1, with two candidate segments at once, and with no valid category, which checks the segment priority and the unconfigured case. After locking, rewrites are chosen so that they would move an access into a differently permitted area if they took effect. A second instance built without execute bits gets the same stimulus, so its fetch refusals can be compared against the full variant.

// File: rtl/spl_pkg.sv
`timescale 1ns/1ps
package spl_pkg;
  localparam int NUM_SEG   = 3;
  localparam int NUM_LINES = 3;
  localparam int NUM_AREAS = NUM_LINES + 1;
  localparam int CAT_W     = 2;
  localparam int CATS_W    = CAT_W * NUM_SEG;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);
  localparam int AREA_W    = $clog2(NUM_AREAS);
  localparam int SEL_W     = $clog2(NUM_LINES + 2);
  localparam int PERM_W    = 3;

  localparam logic [SEL_W-1:0] SEL_LOCK = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_PERM = SEL_W'(NUM_LINES + 1);

  localparam int P_RD = 0;
  localparam int P_WR = 1;
  localparam int P_EX = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/spl_rst_sync.sv
`timescale 1ns/1ps
module spl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/spl_cfg_regs.sv
`timescale 1ns/1ps
module spl_cfg_regs
  import spl_pkg::*;
#(
  parameter int SPLIT_W  = 7,
  parameter int CFG_W    = 13,
  parameter bit HAS_EXEC = 1'b1
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         cfg_we,
  input  logic [SEL_W-1:0]                             cfg_sel,
  input  logic [CFG_W-1:0]                             cfg_wdata,
  output logic                                         lock_q,
  output logic [NUM_LINES-1:0][CATS_W+SPLIT_W-1:0]     split_q,
  output logic [NUM_AREAS-1:0][PERM_W-1:0]             perm_q
);
  localparam int REG_W = CATS_W + SPLIT_W;
  localparam logic [PERM_W-1:0] PERM_MASK = HAS_EXEC ? 3'b111 : 3'b011;

  logic                                 lock_d;
  logic [NUM_LINES-1:0][REG_W-1:0]      split_d;
  logic [NUM_AREAS-1:0][PERM_W-1:0]     perm_d;
  logic                                 wr_open;

  always_comb begin
    wr_open = cfg_we && !lock_q;
    lock_d  = lock_q;
    split_d = split_q;
    perm_d  = perm_q;
    if (cfg_we && (cfg_sel == SEL_LOCK) && cfg_wdata[0]) lock_d = 1'b1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (wr_open && (cfg_sel == SEL_W'(i + 1))) split_d[i] = cfg_wdata[REG_W-1:0];
    end
    if (wr_open && (cfg_sel == SEL_PERM)) begin
      for (int a = 0; a < NUM_AREAS; a++) begin
        perm_d[a] = cfg_wdata[PERM_W*a +: PERM_W] & PERM_MASK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      split_q <= '0;
      perm_q  <= '0;
    end else begin
      lock_q  <= lock_d;
      split_q <= split_d;
      perm_q  <= perm_d;
    end
  end

  // R8: the lock never falls while out of reset
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R9: locked configuration does not move
  p_frozen_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(split_q) && $stable(perm_q)));

  // R11: no execute bit is ever held by the data-side variant
  p_no_exec_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_EXEC |-> (perm_q[0][P_EX] == 1'b0 && perm_q[NUM_AREAS-1][P_EX] == 1'b0));
endmodule

// File: rtl/spl_line_decode.sv
`timescale 1ns/1ps
module spl_line_decode
  import spl_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int              SEG_LOG2  = 16,
  parameter int              LINE_LOG2 = 9
) (
  input  logic [CATS_W+SEG_LOG2-LINE_LOG2-1:0] line_reg,
  output logic                                 line_valid,
  output logic [ADDR_W-1:0]                    line_addr
);
  localparam int SPLIT_W = SEG_LOG2 - LINE_LOG2;

  logic [SEG_IDX_W-1:0] seg_idx;
  logic [CAT_W-1:0]     cat;
  logic [SPLIT_W-1:0]   offs;

  always_comb begin
    line_valid = 1'b0;
    seg_idx    = '0;
    cat        = '0;
    // scan downward so the lowest qualifying segment is the one kept
    for (int s = NUM_SEG - 1; s >= 0; s--) begin
      cat = line_reg[CAT_W*s +: CAT_W];
      if (cat == 2'd1 || cat == 2'd2) begin
        line_valid = 1'b1;
        seg_idx    = SEG_IDX_W'(s);
      end
    end
    offs      = line_reg[CATS_W +: SPLIT_W];
    line_addr = BASE_ADDR + ADDR_W'({seg_idx, offs, {LINE_LOG2{1'b0}}});
  end
endmodule

// File: rtl/spl_access_check.sv
`timescale 1ns/1ps
module spl_access_check
  import spl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter bit HAS_EXEC = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_LINES-1:0]                  line_valid,
  input  logic [NUM_LINES-1:0][ADDR_W-1:0]      line_addr,
  input  logic [NUM_AREAS-1:0][PERM_W-1:0]      perm_q,
  input  logic                                  acc_valid,
  input  logic [ADDR_W-1:0]                     acc_addr,
  input  logic [1:0]                            acc_kind,
  output logic                                  res_valid,
  output logic                                  res_grant,
  output logic                                  res_deny
);
  logic [AREA_W-1:0] area_idx;
  logic [PERM_W-1:0] area_perm;
  logic              allowed;
  logic              valid_d, grant_d, deny_d;
  acc_kind_e         kind;

  always_comb begin
    area_idx = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (line_valid[l] && (line_addr[l] <= acc_addr)) area_idx = area_idx + AREA_W'(1);
    end
    area_perm = perm_q[area_idx];
    kind      = acc_kind_e'(acc_kind);
    unique case (kind)
      ACC_FETCH: allowed = area_perm[P_EX];
      ACC_LOAD:  allowed = area_perm[P_RD];
      ACC_STORE: allowed = area_perm[P_WR];
      default:   allowed = 1'b0;
    endcase
    valid_d = acc_valid;
    grant_d = acc_valid && allowed;
    deny_d  = acc_valid && !allowed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_grant <= 1'b0;
      res_deny  <= 1'b0;
    end else begin
      res_valid <= valid_d;
      res_grant <= grant_d;
      res_deny  <= deny_d;
    end
  end

  // R4: area index never exceeds the number of configured lines
  p_area_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (32'(area_idx) <= $countones(line_valid)));

  // R7: one verdict per result, none without a result
  p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_grant, res_deny}));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!res_valid && !res_grant && !res_deny));

  p_deny_follows_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_deny |-> $past(acc_valid));

  // R6: reserved kind is always refused
  p_rsvd_denied_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd3) |=> res_deny);

  // R11: data-side variant refuses every fetch
  p_fetch_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_EXEC && acc_valid && acc_kind == 2'd0) |=> res_deny);
endmodule

// File: rtl/spl_perm_check.sv
`timescale 1ns/1ps
module spl_perm_check
  import spl_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(32'h4037_0000),
  parameter int                SEG_LOG2  = 16,
  parameter int                LINE_LOG2 = 9,
  parameter bit                HAS_EXEC  = 1'b1,
  localparam int               SPLIT_W   = SEG_LOG2 - LINE_LOG2,
  localparam int               REG_W     = CATS_W + SPLIT_W,
  localparam int               CFG_W     = (REG_W > PERM_W*NUM_AREAS) ? REG_W : PERM_W*NUM_AREAS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              cfg_locked,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  output logic              res_valid,
  output logic              res_grant,
  output logic              res_deny
);
  logic                              rst_ns;
  logic [NUM_LINES-1:0][REG_W-1:0]   split_q;
  logic [NUM_AREAS-1:0][PERM_W-1:0]  perm_q;
  logic [NUM_LINES-1:0]              line_valid;
  logic [NUM_LINES-1:0][ADDR_W-1:0]  line_addr;

  spl_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  spl_cfg_regs #(
    .SPLIT_W  (SPLIT_W),
    .CFG_W    (CFG_W),
    .HAS_EXEC (HAS_EXEC)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_ns),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .lock_q    (cfg_locked),
    .split_q   (split_q),
    .perm_q    (perm_q)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    spl_line_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .SEG_LOG2  (SEG_LOG2),
      .LINE_LOG2 (LINE_LOG2)
    ) u_dec (
      .line_reg   (split_q[g]),
      .line_valid (line_valid[g]),
      .line_addr  (line_addr[g])
    );
  end

  spl_access_check #(
    .ADDR_W   (ADDR_W),
    .HAS_EXEC (HAS_EXEC)
  ) u_chk (
    .clk        (clk),
    .rst_n      (rst_ns),
    .line_valid (line_valid),
    .line_addr  (line_addr),
    .perm_q     (perm_q),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_kind   (acc_kind),
    .res_valid  (res_valid),
    .res_grant  (res_grant),
    .res_deny   (res_deny)
  );

  // R1: lock is clear in the first cycle after reset release
  p_lock_clear_at_start_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(rst_ns) |-> !cfg_locked);
endmodule

// File: tb/sim_spl_perm_check.sv
`timescale 1ns/1ps
module sim_spl_perm_check;
  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_LOAD  = 2'd1;
  localparam logic [1:0] K_STORE = 2'd2;
  localparam logic [1:0] K_RSVD  = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [12:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;

  logic locked0, v0, g0, d0;
  logic locked1, v1, g1, d1;
  logic sv0, sg0, sd0, sg1, sd1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spl_perm_check u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_locked(locked0), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .res_valid(v0), .res_grant(g0), .res_deny(d0)
  );

  spl_perm_check #(.HAS_EXEC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_locked(locked1), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .res_valid(v1), .res_grant(g1), .res_deny(d1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [12:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_access(input logic [31:0] a, input logic [1:0] k);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k;
    @(negedge clk);
    acc_valid = 1'b0;
    sv0 = v0; sg0 = g0; sd0 = d0; sg1 = g1; sd1 = d1;
  endtask

  task automatic expect_acc(input string tag, input logic [31:0] a, input logic [1:0] k,
                            input logic exp_grant);
    do_access(a, k);
    chk(tag, {29'd0, sv0, sg0, sd0}, {29'd0, 1'b1, exp_grant, !exp_grant});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 lock clear after reset", {31'd0, locked0}, 32'd0);
    chk("R1 no result after reset", {29'd0, v0, g0, d0}, 32'd0);
    expect_acc("R1 load denied with empty config", 32'h4037_0000, K_LOAD, 1'b0);
  endtask

  task automatic t_no_lines();
    cfg_write(3'd4, 13'h001);
    expect_acc("R10 top address in area0 load", 32'h4039_FFFC, K_LOAD, 1'b1);
    expect_acc("R10 area0 store refused", 32'h4039_FFFC, K_STORE, 1'b0);
    expect_acc("R5 area0 fetch refused", 32'h4037_0100, K_FETCH, 1'b0);
  endtask

  task automatic t_areas();
    cfg_write(3'd1, 13'h043E);
    cfg_write(3'd2, 13'h00B8);
    cfg_write(3'd3, 13'h1020);
    cfg_write(3'd4, 13'h0F19);
    expect_acc("R4 below line0 area0 load", 32'h4037_1FFC, K_LOAD, 1'b1);
    expect_acc("R4 below line0 area0 store", 32'h4037_1FFC, K_STORE, 1'b0);
    expect_acc("R4 on line0 area1 load", 32'h4037_2000, K_LOAD, 1'b1);
    expect_acc("R2 on line0 area1 fetch", 32'h4037_2000, K_FETCH, 1'b0);
    expect_acc("R2 below line1 area1 store", 32'h4038_03FC, K_STORE, 1'b1);
    expect_acc("R3 on line1 area2 fetch", 32'h4038_0400, K_FETCH, 1'b1);
    chk("R11 no-exec variant refuses fetch", {30'd0, sg1, sd1}, 32'd1);
    expect_acc("R5 area2 load refused", 32'h4038_0400, K_LOAD, 1'b0);
    expect_acc("R4 below line2 area2 load", 32'h4039_7FFC, K_LOAD, 1'b0);
    expect_acc("R4 on line2 area3 store", 32'h4039_8000, K_STORE, 1'b1);
    chk("R11 no-exec variant store in area3", {30'd0, sg1, sd1}, 32'd2);
  endtask

  task automatic t_kinds();
    expect_acc("R6 fetch area3", 32'h4039_9000, K_FETCH, 1'b1);
    expect_acc("R6 load area3", 32'h4039_9000, K_LOAD, 1'b1);
    expect_acc("R6 store area3", 32'h4039_9000, K_STORE, 1'b1);
    expect_acc("R6 reserved kind denied", 32'h4039_9000, K_RSVD, 1'b0);
    do_access(32'h4039_9000, K_FETCH);
    chk("R11 no-exec variant fetch area3", {30'd0, sg1, sd1}, 32'd1);
  endtask

  task automatic t_pulse();
    expect_acc("R7 deny pulse raised", 32'h4037_0000, K_STORE, 1'b0);
    @(negedge clk);
    chk("R7 outputs drop without access", {29'd0, v0, g0, d0}, 32'd0);
  endtask

  task automatic t_category();
    cfg_write(3'd2, 13'h00C4);
    expect_acc("R3 category1 below line", 32'h4038_05FC, K_FETCH, 1'b0);
    expect_acc("R3 category1 on line", 32'h4038_0600, K_FETCH, 1'b1);
    cfg_write(3'd2, 13'h0809);
    expect_acc("R3 lowest segment wins below", 32'h4037_3FFC, K_FETCH, 1'b0);
    expect_acc("R3 lowest segment wins on", 32'h4037_4000, K_FETCH, 1'b1);
    cfg_write(3'd3, 13'h003F);
    expect_acc("R3 unconfigured line store", 32'h4039_9000, K_STORE, 1'b0);
    expect_acc("R3 unconfigured line fetch", 32'h4039_9000, K_FETCH, 1'b1);
  endtask

  task automatic t_lock();
    cfg_write(3'd0, 13'h0000);
    chk("R8 zero write leaves lock clear", {31'd0, locked0}, 32'd0);
    cfg_write(3'd0, 13'h0001);
    chk("R8 lock set", {31'd0, locked0}, 32'd1);
    cfg_write(3'd4, 13'h0000);
    expect_acc("R9 perms kept after locked write", 32'h4037_1000, K_LOAD, 1'b1);
    cfg_write(3'd1, 13'h0000);
    expect_acc("R9 split kept after locked write", 32'h4037_2800, K_STORE, 1'b1);
    cfg_write(3'd0, 13'h0000);
    chk("R8 lock not cleared by software", {31'd0, locked0}, 32'd1);
    do_reset();
    chk("R1 reset clears lock", {31'd0, locked0}, 32'd0);
    expect_acc("R1 perms cleared by reset", 32'h4037_1000, K_LOAD, 1'b0);
  endtask

  initial begin
    t_reset();
    t_no_lines();
    t_areas();
    t_kinds();
    t_pulse();
    t_category();
    t_lock();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule